// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block chooses the next program counter of a word-addressed processor. Each cycle it takes the current instruction word, the already-incremented word PC, the negative (N) and zero (Z) flags and the value of the register named in the instruction's low nibble. From these it decides whether a branch-class instruction is taken. It then forms the target from either a signed relative offset or a register, and it may request a write of the return address into the link register. Flag generation and the register file sit outside the block. The caller reads the source register and presents its value on `reg_val`.

Every instruction falls into one of four paths. SEQ is any non-branch instruction. SKIP is a branch whose condition fails. REL is a taken branch with a relative offset. REG is a taken branch that jumps through a register. The path is decoded with a unique case. Only the REL and REG paths move the PC away from the incremented value or write the link register. The return address is a byte address, four times the incremented word PC, while the PC itself counts words. A next PC of zero raises `halt`, which stops the machine.

All outputs are registered. The result for the inputs sampled at one rising edge appears after that edge. Reset clears every output.

Top module: `branch_link_unit`

## Requirements
- R1: When instr[31:30] is not 2'b11 (SEQ path), next_pc equals pc_inc and link_we is 0.
- R2: For a branch (instr[31:30] = 2'b11), the condition code in instr[27:24] decides whether the branch is taken:
  - code 0: taken when N = 1.
  - code 1: taken when Z = 1.
  - code 5: taken when N = 1.
  - code 6: taken when N or Z is set.
  - code 7: always taken.
  - code 9: taken when Z = 0.
  - code 13: taken when N = 0.
  - code 14: taken when both N and Z are clear.
- R3: Condition codes 2, 3, 4, 8, 10, 11, 12 and 15 are never taken. A branch that is not taken (SKIP path) gives next_pc = pc_inc and link_we = 0, whatever the values of bits 29 and 28.
- R4: A taken branch with instr[29] = 1 (REL path) gives next_pc = pc_inc plus instr[19:0] sign-extended from bit 19, modulo 2^PC_W.
- R5: A taken branch with instr[29] = 0 (REG path) gives next_pc = reg_val divided by 4, that is reg_val[PC_W+1:2].
- R6: link_we is 1 exactly when a branch is taken and instr[28] = 1. Whenever link_we is 1, link_data equals pc_inc multiplied by 4 and zero-extended to DATA_W.
- R7: halt is 1 exactly when the registered next_pc is zero, on every path, and it appears in the same cycle as that next_pc.
- R8: The outputs appear one rising clock edge after their inputs are sampled. While rst_n is low, next_pc, link_we, link_data and halt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Current instruction word |
| pc_inc | input | PC_W | Incremented word PC |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| reg_val | input | DATA_W | Value of the register selected by instr[3:0] |
| next_pc | output | PC_W | Registered next word PC |
| link_we | output | 1 | Link register write enable |
| link_data | output | DATA_W | Byte return address for the link register |
| halt | output | 1 | Next PC is zero |

## Verification
The assertions assume the following about the inputs:
- Every input is a known value at each sampled edge.
- `reg_val` already holds the register named by instr[3:0].
- DATA_W is at least PC_W + 2, so the byte return address always fits.

The stimulus meets these assumptions directly. It drives every input in full on the falling edge. Its reference model treats `reg_val` as that register's contents. Each directed vector and each random vector is built inside the default widths, so every encoding is legal. The random vectors force the top two bits to the branch class about half the time, and they mix in small PC values so that the wrap and zero-target cases occur.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int OFF_W  = 20;
    localparam int COND_W = 4;

    // Defined condition codes; their numeric values are fixed by the encoding.
    localparam logic [COND_W-1:0] CC_NEG      = 4'd0;
    localparam logic [COND_W-1:0] CC_ZERO     = 4'd1;
    localparam logic [COND_W-1:0] CC_NEG_ALT  = 4'd5;
    localparam logic [COND_W-1:0] CC_NOT_POS  = 4'd6;
    localparam logic [COND_W-1:0] CC_ALWAYS   = 4'd7;
    localparam logic [COND_W-1:0] CC_NONZERO  = 4'd9;
    localparam logic [COND_W-1:0] CC_NOT_NEG  = 4'd13;
    localparam logic [COND_W-1:0] CC_POS      = 4'd14;

    // Path an instruction takes through the unit.
    typedef enum logic [1:0] {
        CLS_SEQ  = 2'd0,
        CLS_SKIP = 2'd1,
        CLS_REL  = 2'd2,
        CLS_REG  = 2'd3
    } path_e;

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic              flag_n,
    input  logic              flag_z,
    output logic              taken
);

    always_comb begin
        unique case (cond)
            CC_NEG:     taken = flag_n;
            CC_ZERO:    taken = flag_z;
            CC_NEG_ALT: taken = flag_n;
            CC_NOT_POS: taken = flag_n | flag_z;
            CC_ALWAYS:  taken = 1'b1;
            CC_NONZERO: taken = ~flag_z;
            CC_NOT_NEG: taken = ~flag_n;
            CC_POS:     taken = ~(flag_n | flag_z);
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_path_sel.sv
module bru_path_sel
    import bru_pkg::*;
(
    input  logic  is_branch,
    input  logic  taken,
    input  logic  use_rel,
    output path_e path
);

    always_comb begin
        if (!is_branch)
            path = CLS_SEQ;
        else if (!taken)
            path = CLS_SKIP;
        else if (use_rel)
            path = CLS_REL;
        else
            path = CLS_REG;
    end

endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int DATA_W = 32
) (
    input  path_e             path,
    input  logic [PC_W-1:0]   pc_inc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] reg_val,
    output logic [PC_W-1:0]   target
);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] reg_word;
    logic            unused_rv;

    // Widen or narrow the relative offset to the PC width.
    generate
        if (PC_W > OFF_W) begin : g_sext
            assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[PC_W-1:0];
        end
    endgenerate

    // Byte address in the register becomes a word address.
    assign reg_word  = reg_val[PC_W+1:2];
    assign unused_rv = ^reg_val;

    always_comb begin
        unique case (path)
            CLS_SEQ:  target = pc_inc;
            CLS_SKIP: target = pc_inc;
            CLS_REL:  target = pc_inc + off_ext;
            CLS_REG:  target = reg_word;
            default:  target = pc_inc;
        endcase
    end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
    import bru_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       instr,
    input  logic [PC_W-1:0]   pc_inc,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [DATA_W-1:0] reg_val,
    output logic [PC_W-1:0]   next_pc,
    output logic              link_we,
    output logic [DATA_W-1:0] link_data,
    output logic              halt
);

    localparam int LINK_W = PC_W + 2;

    logic              is_branch;
    logic              use_rel;
    logic              want_link;
    logic              taken;
    path_e             path;
    logic [PC_W-1:0]   target;
    logic              link_we_d;
    logic [DATA_W-1:0] link_data_d;
    logic              unused_ins;

    assign is_branch  = (instr[31:30] == 2'b11);
    assign use_rel    = instr[29];
    assign want_link  = instr[28];
    assign unused_ins = ^instr[23:20];

    bru_cond_eval u_cond (
        .cond   (instr[27:24]),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .taken  (taken)
    );

    bru_path_sel u_sel (
        .is_branch (is_branch),
        .taken     (taken),
        .use_rel   (use_rel),
        .path      (path)
    );

    bru_target #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_tgt (
        .path    (path),
        .pc_inc  (pc_inc),
        .offset  (instr[OFF_W-1:0]),
        .reg_val (reg_val),
        .target  (target)
    );

    // Link request depends on the decoded path.
    always_comb begin
        link_data_d              = '0;
        link_data_d[LINK_W-1:0]  = {pc_inc, 2'b00};
        unique case (path)
            CLS_REL, CLS_REG: link_we_d = want_link;
            default:          link_we_d = 1'b0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc   <= '0;
            link_we   <= 1'b0;
            link_data <= '0;
            halt      <= 1'b0;
        end else begin
            next_pc   <= target;
            link_we   <= link_we_d;
            link_data <= link_data_d;
            halt      <= (target == '0);
        end
    end

endmodule

// File: rtl/branch_link_unit_chk.sv
module branch_link_unit_chk #(
    parameter int PC_W   = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr,
    input logic [PC_W-1:0]   pc_inc,
    input logic              flag_n,
    input logic              flag_z,
    input logic [DATA_W-1:0] reg_val,
    input logic [PC_W-1:0]   next_pc,
    input logic              link_we,
    input logic [DATA_W-1:0] link_data,
    input logic              halt
);

    logic            br_in;
    logic            undef_cc;
    logic [PC_W-1:0] rel_exp;
    logic [PC_W-1:0] reg_exp;
    logic            unused_chk;

    assign br_in    = (instr[31:30] == 2'b11);
    assign undef_cc = (instr[27:24] == 4'd2)  || (instr[27:24] == 4'd3)  ||
                      (instr[27:24] == 4'd4)  || (instr[27:24] == 4'd8)  ||
                      (instr[27:24] == 4'd10) || (instr[27:24] == 4'd11) ||
                      (instr[27:24] == 4'd12) || (instr[27:24] == 4'd15);
    assign rel_exp  = pc_inc + PC_W'($signed(instr[19:0]));
    assign reg_exp  = reg_val[PC_W+1:2];
    assign unused_chk = ^{flag_z, reg_val, link_data};

    AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(br_in)) |-> (next_pc == $past(pc_inc) && !link_we)); // R1

    AST_NEG_CLEAR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_in) && $past(instr[27:24]) == 4'd0 && !$past(flag_n))
        |-> (next_pc == $past(pc_inc) && !link_we)); // R2

    AST_UNDEF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_in) && $past(undef_cc))
        |-> (next_pc == $past(pc_inc) && !link_we)); // R3

    AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_in) && $past(instr[27:24]) == 4'd7 && $past(instr[29]))
        |-> (next_pc == $past(rel_exp))); // R4

    AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_in) && $past(instr[27:24]) == 4'd7 && !$past(instr[29]))
        |-> (next_pc == $past(reg_exp))); // R5

    AST_LINK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> ($past(br_in) && $past(instr[28]) && link_data[1:0] == 2'b00)); // R6

    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (halt == (next_pc == '0))); // R7

endmodule

bind branch_link_unit branch_link_unit_chk #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .pc_inc    (pc_inc),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .reg_val   (reg_val),
    .next_pc   (next_pc),
    .link_we   (link_we),
    .link_data (link_data),
    .halt      (halt)
);

// File: tb/branch_link_unit_bench.sv
module branch_link_unit_bench;

    localparam int PC_W   = 24;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       instr = '0;
    logic [PC_W-1:0]   pc_inc = '0;
    logic              flag_n = 1'b0;
    logic              flag_z = 1'b0;
    logic [DATA_W-1:0] reg_val = '0;
    logic [PC_W-1:0]   next_pc;
    logic              link_we;
    logic [DATA_W-1:0] link_data;
    logic              halt;

    int errors = 0;
    int checks = 0;

    logic              pend = 1'b0;
    string             pend_tag;
    logic [PC_W-1:0]   e_pc;
    logic              e_we;
    logic [DATA_W-1:0] e_ld;
    logic              e_halt;

    always #5 clk = ~clk;

    branch_link_unit #(.PC_W(PC_W), .DATA_W(DATA_W)) u_branch_link_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc_inc(pc_inc),
        .flag_n(flag_n), .flag_z(flag_z), .reg_val(reg_val),
        .next_pc(next_pc), .link_we(link_we), .link_data(link_data), .halt(halt)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: decides the expected outputs for one input set.
    task automatic model(input logic [31:0] ins, input logic [PC_W-1:0] pc,
                         input logic n, input logic z, input logic [DATA_W-1:0] rv);
        bit tk;
        longint mask = (longint'(1) << PC_W) - 1;
        longint tgt = pc;
        int cc = ins[27:24];
        case (cc)
            0:  tk = n;
            1:  tk = z;
            5:  tk = n;
            6:  tk = n || z;
            7:  tk = 1;
            9:  tk = !z;
            13: tk = !n;
            14: tk = !(n || z);
            default: tk = 0;
        endcase
        if (ins[31:30] != 2'b11) tk = 0;
        if (tk) begin
            if (ins[29]) begin
                longint off = ins[19:0];
                if (off >= 524288) off = off - 1048576;
                tgt = (longint'(pc) + off) & mask;
            end else begin
                tgt = (longint'(rv) / 4) & mask;
            end
        end
        e_pc   = tgt[PC_W-1:0];
        e_we   = tk && ins[28];
        e_ld   = DATA_W'(longint'(pc) * 4);
        e_halt = (tgt == 0);
    endtask

    task automatic compare_pending();
        if (pend) begin
            check(pend_tag, "next_pc", next_pc, e_pc);
            check("R6", "link_we", link_we, e_we);
            if (e_we) check("R6", "link_data", link_data, e_ld);
            check("R7", "halt", halt, e_halt);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [PC_W-1:0] pc,
                         input logic n, input logic z, input logic [DATA_W-1:0] rv,
                         input string tag);
        @(negedge clk);
        compare_pending();
        instr = ins; pc_inc = pc; flag_n = n; flag_z = z; reg_val = rv;
        model(ins, pc, n, z, rv);
        pend_tag = tag;
        pend = 1'b1;
    endtask

    function automatic logic [31:0] br(input bit u, input bit v, input int cc, input logic [19:0] low);
        return {2'b11, u, v, 4'(cc), 4'h0, low};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        instr = br(1, 1, 7, 20'h00010);
        pc_inc = 24'h000100;
        @(negedge clk);
        check("R8", "reset next_pc", next_pc, 0);
        check("R8", "reset link_we", link_we, 0);
        check("R8", "reset link_data", link_data, 0);
        check("R8", "reset halt", halt, 0);
        rst_n = 1'b1;

        // R1: non-branch classes
        apply(32'h4800_1234, 24'h000101, 1, 1, 32'h0000_0040, "R1");
        apply(32'h8312_0004, 24'h000102, 0, 0, 32'h0000_0040, "R1");
        apply(32'hB312_0004, 24'hFFFFFF, 1, 0, 32'h0000_0040, "R1");
        apply(32'h0000_0000, 24'h000000, 0, 0, 32'h0, "R7");

        // R2: every defined code under every flag pair
        foreach (e_ld[i]) ; // no-op keeps loop style consistent
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 4; f++) begin
                apply(br(1, 0, cc, 20'h00020), 24'h000200, f[1], f[0], 32'h0, "R2");
            end
        end

        // R3: undefined codes with link and relative bits set
        for (int k = 0; k < 8; k++) begin
            int codes[8] = '{2, 3, 4, 8, 10, 11, 12, 15};
            apply(br(1, 1, codes[k], 20'h00100), 24'h000300, k[0], k[1], 32'h400, "R3");
            apply(br(0, 1, codes[k], 20'h00005), 24'h000300, 1, 1, 32'h400, "R3");
        end

        // R4: negative offset, wrap past zero, exact zero
        apply(br(1, 0, 7, 20'hFFFF0), 24'h000100, 0, 0, 32'h0, "R4");
        apply(br(1, 0, 7, 20'hFFFFE), 24'h000001, 0, 0, 32'h0, "R4");
        apply(br(1, 0, 7, 20'h7FFFF), 24'hFFFFF0, 0, 0, 32'h0, "R4");
        apply(br(1, 0, 7, 20'hFFFF0), 24'h000010, 0, 0, 32'h0, "R7");

        // R5: register targets
        apply(br(0, 0, 7, 20'h00003), 24'h000400, 0, 0, 32'h0000_1234, "R5");
        apply(br(0, 0, 9, 20'h0000C), 24'h000400, 0, 0, 32'hFFFF_FFFC, "R5");
        apply(br(0, 0, 7, 20'h00001), 24'h000400, 0, 0, 32'h0000_0003, "R7");

        // R6: link writes on taken and untaken branches
        apply(br(1, 1, 7, 20'h00004), 24'hFFFFFF, 0, 0, 32'h0, "R6");
        apply(br(0, 1, 13, 20'h0000F), 24'h123456, 0, 1, 32'h0000_0800, "R6");
        apply(br(0, 1, 13, 20'h0000F), 24'h123456, 1, 0, 32'h0000_0800, "R6");

        // Mixed stimulus
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins = $urandom;
            logic [PC_W-1:0] pc = PC_W'($urandom);
            if ($urandom % 2 == 0) ins[31:30] = 2'b11;
            if ($urandom % 4 == 0) pc = PC_W'($urandom % 32);
            apply(ins, pc, 1'($urandom), 1'($urandom), $urandom, "R2");
        end

        @(negedge clk);
        compare_pending();
        pend = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule